// File: doc/BRIEF.md
# Per-Block Program/Erase Protection Controller

This block holds a protection level for every block of a 71-block flash array and decides whether each program or erase request may go ahead. Commands arrive one per cycle as an operation code plus a block index. They can lock a block, unlock it, or lock it down. A locked-down level is sticky: it can only be left through a reset. Reset returns every block to the locked level.

A separate request port carries an operation kind and a target block. One cycle later the block answers with a response strobe and a grant bit. A command and a request may arrive in the same cycle for the same block. In that case the decision already uses the level the command produces, so a level change acts at once.

A supply-lockout input overrides every block. While it is high, all program and erase requests are denied. Reads are never restricted. A query port returns the stored level of any block index, so software-visible state can be observed at the pins.

Top module: `prot_guard`

## Requirements
- R1: Synchronous active-high reset puts every block in the locked level (code 01) and clears `rsp_valid`.
- R2: `qry_state` shows, in the same cycle, the stored level of block `qry_blk`. The codes are 00 unlocked, 01 locked and 11 locked-down, and code 10 never appears. An index of 71 or above reads back as 01.
- R3: The `cmd_op` codes are 00 none, 01 lock, 10 unlock and 11 lock-down. When `cmd_valid` is high, the addressed block takes its new level at the next clock edge. Commands addressed to index 71 or above change nothing.
- R4: A locked-down block stays locked-down whatever lock or unlock commands it receives, until the next reset.
- R5: While `vpp_low` is high, every program or erase request is denied, whatever the block's level.
- R6: A read request (`req_op` 00) is always granted, whatever the level, the index or `vpp_low`.
- R7: A program request (`req_op` 01) or an erase request (`req_op` 10) is granted only when the target index is below 71, the block is unlocked and `vpp_low` is low. The code 11 is reserved and is always denied.
- R8: Each request with `req_valid` high produces exactly one cycle of `rsp_valid` high, in the cycle after the request. `rsp_valid` is low in every other cycle.
- R9: A command and a request to the same block in the same cycle are decided using the level after the command.
- R10: A command to one block leaves the level of every other block unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code: 00 none, 01 lock, 10 unlock, 11 lock-down |
| cmd_blk | input | 7 | Block index addressed by the command |
| req_valid | input | 1 | Access request strobe |
| req_op | input | 2 | Request kind: 00 read, 01 program, 10 erase, 11 reserved |
| req_blk | input | 7 | Block index the request targets |
| vpp_low | input | 1 | Programming supply below its lockout threshold |
| qry_blk | input | 7 | Block index to report |
| qry_state | output | 2 | Level of the queried block |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_grant | output | 1 | 1 = operation permitted |

## Verification
A grant decision is due exactly one clock edge after its request. The driver task pushes the expected grant, computed from a level model of all 71 blocks, into a queue when it applies a request. The monitor pops and compares an item on every falling edge where `rsp_valid` is high, so each answer is matched in arrival order at the cycle it must appear. A level change becomes visible on `qry_state` after the edge that follows the command, so queries are made at the next falling edge plus a small settle delay. The request path is decided from the post-command level in the same cycle, and the same-cycle cases check this.

// File: rtl/prot_pkg.sv
package prot_pkg;

    localparam int NBLK  = 71;
    localparam int IDX_W = 7;

    typedef enum logic [1:0] {
        LVL_OPEN   = 2'b00,
        LVL_LOCKED = 2'b01,
        LVL_FROZEN = 2'b11
    } prot_lvl_e;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'b00,
        CMD_LOCK   = 2'b01,
        CMD_UNLOCK = 2'b10,
        CMD_FREEZE = 2'b11
    } prot_cmd_e;

    typedef enum logic [1:0] {
        REQ_READ  = 2'b00,
        REQ_PROG  = 2'b01,
        REQ_ERASE = 2'b10,
        REQ_RSVD  = 2'b11
    } prot_req_e;

    typedef struct packed {
        logic valid;
        logic grant;
    } prot_rsp_t;

    // Level after applying one command to a block currently at cur.
    function automatic prot_lvl_e next_lvl(input prot_lvl_e cur, input prot_cmd_e op);
        prot_lvl_e nxt;
        nxt = cur;
        case (op)
            CMD_LOCK:   nxt = (cur == LVL_FROZEN) ? LVL_FROZEN : LVL_LOCKED;
            CMD_UNLOCK: nxt = (cur == LVL_FROZEN) ? LVL_FROZEN : LVL_OPEN;
            CMD_FREEZE: nxt = LVL_FROZEN;
            default:    nxt = cur;
        endcase
        return nxt;
    endfunction

    // Permission rule for one request.
    function automatic logic may_access(input prot_req_e op, input prot_lvl_e lvl,
                                        input logic in_range, input logic supply_low);
        logic ok;
        case (op)
            REQ_READ:            ok = 1'b1;
            REQ_PROG, REQ_ERASE: ok = in_range && (lvl == LVL_OPEN) && !supply_low;
            default:             ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/prot_cell.sv
module prot_cell
    import prot_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hit,
    input  prot_cmd_e op,
    output prot_lvl_e lvl_q,
    output prot_lvl_e lvl_d
);

    always_comb begin
        lvl_d = hit ? next_lvl(lvl_q, op) : lvl_q;
    end

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= LVL_LOCKED;
        else     lvl_q <= lvl_d;
    end

endmodule

// File: rtl/prot_decide.sv
module prot_decide
    import prot_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid,
    input  prot_req_e req_op,
    input  prot_lvl_e tgt_lvl,
    input  logic      tgt_in_range,
    input  logic      supply_low,
    output prot_rsp_t rsp
);

    prot_rsp_t rsp_d;

    always_comb begin
        rsp_d.valid = req_valid;
        rsp_d.grant = req_valid && may_access(req_op, tgt_lvl, tgt_in_range, supply_low);
    end

    always_ff @(posedge clk) begin
        if (rst) rsp <= '0;
        else     rsp <= rsp_d;
    end

endmodule

// File: rtl/prot_guard.sv
module prot_guard
    import prot_pkg::*;
#(
    parameter int N_BLK = NBLK,
    parameter int BW    = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [BW-1:0] cmd_blk,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [BW-1:0] req_blk,
    input  logic          vpp_low,
    input  logic [BW-1:0] qry_blk,
    output logic [1:0]    qry_state,
    output logic          rsp_valid,
    output logic          rsp_grant
);

    localparam int NSLOT = 1 << BW;

    prot_lvl_e lvl_q [NSLOT];
    prot_lvl_e lvl_d [NSLOT];
    prot_cmd_e cmd_e_w;
    prot_rsp_t rsp;
    logic      req_in_range;

    assign cmd_e_w      = prot_cmd_e'(cmd_op);
    assign req_in_range = (int'(req_blk) < N_BLK);

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        if (i < N_BLK) begin : g_real
            prot_cell u_cell (
                .clk   (clk),
                .rst   (rst),
                .hit   (cmd_valid && (cmd_blk == BW'(i))),
                .op    (cmd_e_w),
                .lvl_q (lvl_q[i]),
                .lvl_d (lvl_d[i])
            );
        end else begin : g_pad
            assign lvl_q[i] = LVL_LOCKED;
            assign lvl_d[i] = LVL_LOCKED;
        end
    end

    prot_decide u_decide (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_op       (prot_req_e'(req_op)),
        .tgt_lvl      (lvl_d[req_blk]),
        .tgt_in_range (req_in_range),
        .supply_low   (vpp_low),
        .rsp          (rsp)
    );

    assign qry_state = lvl_q[qry_blk];
    assign rsp_valid = rsp.valid;
    assign rsp_grant = rsp.grant;

endmodule

// File: rtl/prot_guard_chk.sv
module prot_guard_chk #(
    parameter int BW = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic [1:0]    req_op,
    input logic          vpp_low,
    input logic [BW-1:0] qry_blk,
    input logic [1:0]    qry_state,
    input logic          rsp_valid,
    input logic          rsp_grant
);

    // R1: first cycle out of reset shows the locked code
    a_r1_reset_locked: assert property (@(posedge clk)
        (!rst && $past(rst)) |-> (qry_state == 2'b01));

    // R2: the unused code never shows
    a_r2_no_code10: assert property (@(posedge clk) disable iff (rst)
        qry_state != 2'b10);

    // R4: locked-down persists while the same block is watched
    a_r4_frozen_sticky: assert property (@(posedge clk) disable iff (rst)
        (qry_state == 2'b11 && $stable(qry_blk)) |=> (qry_state == 2'b11 || !$stable(qry_blk)));

    // R5: supply lockout denies program and erase
    a_r5_supply_deny: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op != 2'b00 && vpp_low) |=> (rsp_valid && !rsp_grant));

    // R6: reads always granted
    a_r6_read_grant: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b00) |=> (rsp_valid && rsp_grant));

    // R8: one response per request, one cycle later
    a_r8_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

endmodule

bind prot_guard prot_guard_chk #(.BW(BW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .vpp_low   (vpp_low),
    .qry_blk   (qry_blk),
    .qry_state (qry_state),
    .rsp_valid (rsp_valid),
    .rsp_grant (rsp_grant)
);

// File: tb/prot_guard_test.sv
module prot_guard_test;

    localparam int NB = 71;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [6:0] cmd_blk = '0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic [6:0] req_blk = '0;
    logic       vpp_low = 1'b0;
    logic [6:0] qry_blk = '0;
    logic [1:0] qry_state;
    logic       rsp_valid;
    logic       rsp_grant;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        bit    g;
        string tag;
    } exp_t;
    exp_t sb[$];

    logic [1:0] model [NB];

    always #5 clk = ~clk;

    prot_guard uut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
        .req_valid(req_valid), .req_op(req_op), .req_blk(req_blk),
        .vpp_low(vpp_low), .qry_blk(qry_blk), .qry_state(qry_state),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant)
    );

    function automatic logic [1:0] apply(input logic [1:0] cur, input logic [1:0] op);
        if (cur == 2'b11) return 2'b11;
        case (op)
            2'b01:   return 2'b01;
            2'b10:   return 2'b00;
            2'b11:   return 2'b11;
            default: return cur;
        endcase
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Monitor: pops expected grants as responses appear
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R8 unexpected response: actual grant=%0b expected none", rsp_grant);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rsp_grant !== e.g) begin
                    fails++;
                    $display("FAIL %s grant actual=%0b expected=%0b", e.tag, rsp_grant, e.g);
                end
            end
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        foreach (model[i]) model[i] = 2'b01;
        sb.delete();
    endtask

    // Driver: applies one cycle of stimulus, pushes the expected grant
    task automatic step(input bit cv, input logic [1:0] co, input int cb,
                        input bit rv, input logic [1:0] ro, input int rb, input string tag);
        bit g;
        logic [1:0] lv;
        cmd_valid = cv; cmd_op = co; cmd_blk = 7'(cb);
        req_valid = rv; req_op = ro; req_blk = 7'(rb);
        if (cv && cb < NB) model[cb] = apply(model[cb], co);
        if (rv) begin
            lv = (rb < NB) ? model[rb] : 2'b01;
            if (ro == 2'b00)      g = 1'b1;
            else if (ro == 2'b11) g = 1'b0;
            else                  g = (rb < NB) && (lv == 2'b00) && !vpp_low;
            sb.push_back('{g, tag});
        end
        @(negedge clk);
        cmd_valid = 1'b0; req_valid = 1'b0;
    endtask

    task automatic see(input int b, input logic [1:0] exp, input string tag);
        qry_blk = 7'(b);
        #1;
        checks++;
        if (qry_state !== exp) begin
            fails++;
            $display("FAIL %s state of block %0d actual=%b expected=%b", tag, b, qry_state, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        checks++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 rsp_valid actual=%b expected=0", rsp_valid);
        end
        for (int i = 0; i < NB; i++) see(i, 2'b01, "R1");

        // R7 locked blocks deny, R6 read passes
        step(0, 2'b00, 0, 1, 2'b01, 5, "R7 prog locked");
        step(0, 2'b00, 0, 1, 2'b00, 5, "R6 read locked");
        // R3 unlock, R10 neighbour untouched
        step(1, 2'b10, 5, 0, 2'b00, 0, "");
        see(5, 2'b00, "R3");
        see(6, 2'b01, "R10");
        see(4, 2'b01, "R10");
        step(0, 2'b00, 0, 1, 2'b01, 5, "R7 prog open");
        step(0, 2'b00, 0, 1, 2'b10, 5, "R7 erase open");
        step(0, 2'b00, 0, 1, 2'b11, 5, "R7 reserved");
        // R5 supply lockout
        vpp_low = 1'b1;
        step(0, 2'b00, 0, 1, 2'b01, 5, "R5 prog lowsupply");
        step(0, 2'b00, 0, 1, 2'b10, 5, "R5 erase lowsupply");
        step(0, 2'b00, 0, 1, 2'b00, 5, "R6 read lowsupply");
        vpp_low = 1'b0;
        step(0, 2'b00, 0, 1, 2'b01, 5, "R5 supply restored");
        // R9 same-cycle command and request
        step(1, 2'b10, 9, 1, 2'b01, 9, "R9 unlock+prog");
        step(1, 2'b01, 5, 1, 2'b10, 5, "R9 lock+erase");
        see(5, 2'b01, "R3");
        // R4 lock-down is sticky
        step(1, 2'b11, 20, 0, 2'b00, 0, "");
        see(20, 2'b11, "R4");
        step(1, 2'b10, 20, 1, 2'b01, 20, "R4 unlock ignored");
        see(20, 2'b11, "R4");
        step(1, 2'b01, 20, 0, 2'b00, 0, "");
        see(20, 2'b11, "R4");
        step(1, 2'b11, 21, 1, 2'b01, 21, "R9 freeze+prog");
        // R3 out-of-range, R2 query of padding
        step(1, 2'b10, 71, 1, 2'b01, 71, "R7 out of range");
        see(71, 2'b01, "R2");
        see(127, 2'b01, "R2");
        step(0, 2'b00, 0, 1, 2'b00, 127, "R6 read out of range");
        // boundaries
        step(1, 2'b10, 0, 0, 2'b00, 0, "");
        step(1, 2'b10, 70, 1, 2'b10, 0, "R7 block0 erase");
        step(0, 2'b00, 0, 1, 2'b01, 70, "R7 block70 prog");
        see(70, 2'b00, "R3");
        see(69, 2'b01, "R10");
        step(1, 2'b00, 70, 1, 2'b01, 70, "R3 none op");
        // R1 reset clears lock-down
        do_reset();
        see(20, 2'b01, "R1");
        see(9, 2'b01, "R1");
        step(0, 2'b00, 0, 1, 2'b01, 9, "R1 prog after reset");
        @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R8 missing responses actual=%0d expected=0", sb.size());
        end
        finish_run();
    end

endmodule